// File: doc/BRIEF.md
# Operand-Waiting Station Pool

This block holds operations for one class of execution unit in an out-of-order core, an adder pool for example, until their operands exist. The issue stage hands it an operation with two sources. Each source is either a value copied from the register file or the tag of the station that will produce it. The pool stores the operation in a free station and returns that station's tag, so the rename logic can record it as the producer. When every station is occupied, the pool lowers its ready signal and issue stalls.

Every cycle each waiting station compares the tag on the shared result-broadcast bus with its missing sources. On a match it latches the broadcast value. A station whose sources are all present is eligible to fire. Among the eligible stations, the one issued earliest is offered to the single execution-unit port. A station stays occupied after it fires and frees in the cycle its own tag appears on the result bus. A flush empties the whole pool in one cycle.

Top module: `rs_pool`

## Requirements
- R1: `iss_ready` is high exactly when at least one station is free. `iss_tag` is `{POOL_ID, index}` of the lowest-numbered free station. With the defaults (POOL_ID=1, three stations) the tags are 4'h4, 4'h5 and 4'h6, and after reset `iss_tag` is 4'h4.
- R2: An issue presented while `iss_ready` is low is ignored. It takes no station and is never offered to the unit.
- R3: A source marked ready at issue keeps the value supplied at issue. The dispatched `fu_op`, `fu_a` and `fu_b` equal the issued operation and values, and `fu_tag` is the station's tag.
- R4: A source that is waiting on a tag takes `bus_value` in the first cycle that `bus_valid` is high with a matching `bus_tag`. A broadcast with any other tag leaves the source waiting.
- R5: If the result bus carries a pending source's tag in the issue cycle itself, the value is captured at issue.
- R6: `fu_valid` is high only while some station has both sources present and has not yet fired.
- R7: When several stations are eligible, the one issued earliest is offered, whatever its station index.
- R8: While `fu_ready` is low, an offered station stays eligible. When `fu_valid` and `fu_ready` are both high, that station fires and is never offered again.
- R9: A fired station stays occupied until the result bus carries its own tag. It is free from the next cycle.
- R10: `flush` frees every station by the next cycle, whatever state each one is in.
- R11: Issue order is kept when a station frees and its slot is reused. A newly issued station in a low index is younger than older stations in higher indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties all stations |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to hold |
| iss_a_rdy | input | 1 | Source A carries a value |
| iss_a_val | input | DATA_W | Source A value |
| iss_a_tag | input | TAG_W | Source A producer tag |
| iss_b_rdy | input | 1 | Source B carries a value |
| iss_b_val | input | DATA_W | Source B value |
| iss_b_tag | input | TAG_W | Source B producer tag |
| iss_ready | output | 1 | A station is free |
| iss_tag | output | TAG_W | Tag of the station that takes the next issue |
| bus_valid | input | 1 | Result bus broadcast present |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_value | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Execution unit accepts an operation |
| fu_valid | output | 1 | An eligible station is offered |
| fu_op | output | OP_W | Offered operation |
| fu_a | output | DATA_W | Offered source A |
| fu_b | output | DATA_W | Offered source B |
| fu_tag | output | TAG_W | Tag of the offered station |

## Verification
The bench targets the points where a result and an issue meet: a broadcast that arrives in the issue cycle itself, and a broadcast that carries a foreign tag. A design without the issue bypass leaves that station waiting forever. A design with a loose tag compare fires with a wrong operand. Age is checked with the oldest station waiting on a late operand while younger ones are eligible, and again after a slot frees and is reused. An index-priority picker would dispatch the wrong tag in both cases. The bench also checks that a fired station is not offered twice, stays occupied until its own broadcast, and that a full pool drops a stalled issue.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_INFLT = 2'd2
    } st_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int unsigned N     = 3,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N-1:0]     free_vec,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int unsigned N     = 3,
    parameter int unsigned SEQ_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              req,
    input  logic [N-1:0][SEQ_W-1:0]   seq,
    output logic                      any_req,
    output logic [N-1:0]              grant
);
    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        any_req  = 1'b0;
        grant    = '0;
        best_seq = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any_req || seq[i] < best_seq)) begin
                any_req  = 1'b1;
                grant    = '0;
                grant[i] = 1'b1;
                best_seq = seq[i];
            end
        end
    end

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned SEQ_W  = 2,
    parameter logic [TAG_W-1:0] MY_TAG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic              in_a_rdy,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic              in_b_rdy,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              fire,
    input  logic              free_any,
    input  logic [SEQ_W-1:0]  free_seq,
    output logic              is_free,
    output logic              is_ready,
    output logic              freeing,
    output logic [SEQ_W-1:0]  seq,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    typedef struct packed {
        st_e               st;
        logic [OP_W-1:0]   op;
        logic [SEQ_W-1:0]  seq;
        logic              a_rdy;
        logic [DATA_W-1:0] a_val;
        logic [TAG_W-1:0]  a_tag;
        logic              b_rdy;
        logic [DATA_W-1:0] b_val;
        logic [TAG_W-1:0]  b_tag;
    } ent_t;

    ent_t s_d, s_q;
    logic hit_a, hit_b, self_free;

    always_comb begin
        s_d       = s_q;
        hit_a     = bus_valid && !s_q.a_rdy && (bus_tag == s_q.a_tag);
        hit_b     = bus_valid && !s_q.b_rdy && (bus_tag == s_q.b_tag);
        self_free = (s_q.st == ST_INFLT) && bus_valid && (bus_tag == MY_TAG);
        if (flush) begin
            s_d.st = ST_FREE;
        end else begin
            unique case (s_q.st)
                ST_FREE: begin
                    if (alloc) begin
                        s_d.st    = ST_WAIT;
                        s_d.op    = in_op;
                        s_d.seq   = in_seq;
                        s_d.a_tag = in_a_tag;
                        s_d.b_tag = in_b_tag;
                        s_d.a_rdy = in_a_rdy || (bus_valid && bus_tag == in_a_tag);
                        s_d.a_val = in_a_rdy ? in_a_val : bus_value;
                        s_d.b_rdy = in_b_rdy || (bus_valid && bus_tag == in_b_tag);
                        s_d.b_val = in_b_rdy ? in_b_val : bus_value;
                    end
                end
                ST_WAIT: begin
                    if (hit_a) begin
                        s_d.a_rdy = 1'b1;
                        s_d.a_val = bus_value;
                    end
                    if (hit_b) begin
                        s_d.b_rdy = 1'b1;
                        s_d.b_val = bus_value;
                    end
                    if (fire) s_d.st = ST_INFLT;
                end
                ST_INFLT: begin
                    if (self_free) s_d.st = ST_FREE;
                end
                default: s_d.st = ST_FREE;
            endcase
            if (s_q.st != ST_FREE && free_any && !self_free && s_q.seq > free_seq)
                s_d.seq = s_q.seq - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_FREE;
        end else begin
            s_q <= s_d;
        end
    end

    assign is_free  = (s_q.st == ST_FREE);
    assign is_ready = (s_q.st == ST_WAIT) && s_q.a_rdy && s_q.b_rdy;
    assign freeing  = self_free;
    assign seq      = s_q.seq;
    assign op       = s_q.op;
    assign a_val    = s_q.a_val;
    assign b_val    = s_q.b_val;

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT && !s_q.a_rdy && bus_valid && bus_tag == s_q.a_tag && !flush)
        |=> (s_q.a_rdy && s_q.a_val == $past(bus_value)));

    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !in_b_rdy && bus_valid && bus_tag == in_b_tag && !flush)
        |=> (s_q.b_rdy && s_q.b_val == $past(bus_value)));

    p_fire_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (s_q.st == ST_WAIT && s_q.a_rdy && s_q.b_rdy));

    p_hold_until_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_INFLT && !flush && !(bus_valid && bus_tag == MY_TAG))
        |=> (s_q.st == ST_INFLT));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.st == ST_FREE));
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int unsigned NUM_ST  = 3,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned OP_W    = 4,
    parameter int unsigned POOL_W  = 2,
    parameter int unsigned POOL_ID = 1,
    localparam int unsigned IDX_W  = width_of(NUM_ST),
    localparam int unsigned SEQ_W  = width_of(NUM_ST),
    localparam int unsigned TAG_W  = POOL_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_rdy,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic              iss_b_rdy,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              fu_ready,
    output logic              fu_valid,
    output logic [OP_W-1:0]   fu_op,
    output logic [DATA_W-1:0] fu_a,
    output logic [DATA_W-1:0] fu_b,
    output logic [TAG_W-1:0]  fu_tag
);
    localparam int unsigned CNT_W = $clog2(NUM_ST + 1);

    logic [NUM_ST-1:0]             free_vec, ready_vec, freeing_vec, grant, alloc_vec;
    logic [NUM_ST-1:0][SEQ_W-1:0]  seq_vec;
    logic [NUM_ST-1:0][OP_W-1:0]   op_vec;
    logic [NUM_ST-1:0][DATA_W-1:0] a_vec, b_vec;
    logic [IDX_W-1:0]              free_idx;
    logic                          any_free, free_any;
    logic [SEQ_W-1:0]              free_seq, alloc_seq;
    logic [CNT_W-1:0]              busy_cnt;

    rs_free_pick #(.N(NUM_ST), .IDX_W(IDX_W)) u_free_pick (
        .free_vec (free_vec),
        .any_free (any_free),
        .idx      (free_idx)
    );

    rs_oldest_pick #(.N(NUM_ST), .SEQ_W(SEQ_W)) u_oldest_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ready_vec),
        .seq     (seq_vec),
        .any_req (fu_valid),
        .grant   (grant)
    );

    always_comb begin
        busy_cnt = '0;
        free_any = 1'b0;
        free_seq = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            busy_cnt = busy_cnt + CNT_W'(!free_vec[i]);
            if (freeing_vec[i]) begin
                free_any = 1'b1;
                free_seq = seq_vec[i];
            end
        end
        alloc_seq = SEQ_W'(busy_cnt - CNT_W'(free_any));
    end

    always_comb begin
        fu_op  = '0;
        fu_a   = '0;
        fu_b   = '0;
        fu_tag = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (grant[i]) begin
                fu_op  = op_vec[i];
                fu_a   = a_vec[i];
                fu_b   = b_vec[i];
                fu_tag = {POOL_W'(POOL_ID), IDX_W'(i)};
            end
        end
    end

    assign iss_ready = any_free;
    assign iss_tag   = {POOL_W'(POOL_ID), free_idx};

    for (genvar g = 0; g < NUM_ST; g++) begin : g_st
        localparam logic [TAG_W-1:0] ST_TAG = {POOL_W'(POOL_ID), IDX_W'(g)};

        assign alloc_vec[g] = iss_valid && any_free && (free_idx == IDX_W'(g));

        rs_station #(
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .TAG_W  (TAG_W),
            .SEQ_W  (SEQ_W),
            .MY_TAG (ST_TAG)
        ) u_station (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .alloc     (alloc_vec[g]),
            .in_op     (iss_op),
            .in_a_rdy  (iss_a_rdy),
            .in_a_val  (iss_a_val),
            .in_a_tag  (iss_a_tag),
            .in_b_rdy  (iss_b_rdy),
            .in_b_val  (iss_b_val),
            .in_b_tag  (iss_b_tag),
            .in_seq    (alloc_seq),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .fire      (grant[g] && fu_ready),
            .free_any  (free_any),
            .free_seq  (free_seq),
            .is_free   (free_vec[g]),
            .is_ready  (ready_vec[g]),
            .freeing   (freeing_vec[g]),
            .seq       (seq_vec[g]),
            .op        (op_vec[g]),
            .a_val     (a_vec[g]),
            .b_val     (b_vec[g])
        );
    end

    p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (busy_cnt <= $past(busy_cnt)));

    p_ready_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready == (busy_cnt < CNT_W'(NUM_ST)));

    p_offer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_valid && !fu_ready && !flush) |=> fu_valid);
endmodule

// File: tb/rs_pool_bench.sv
module rs_pool_bench;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int TAG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              iss_valid = 1'b0;
    logic [OP_W-1:0]   iss_op = '0;
    logic              iss_a_rdy = 1'b0;
    logic [DATA_W-1:0] iss_a_val = '0;
    logic [TAG_W-1:0]  iss_a_tag = '0;
    logic              iss_b_rdy = 1'b0;
    logic [DATA_W-1:0] iss_b_val = '0;
    logic [TAG_W-1:0]  iss_b_tag = '0;
    logic              iss_ready;
    logic [TAG_W-1:0]  iss_tag;
    logic              bus_valid = 1'b0;
    logic [TAG_W-1:0]  bus_tag = '0;
    logic [DATA_W-1:0] bus_value = '0;
    logic              fu_ready = 1'b0;
    logic              fu_valid;
    logic [OP_W-1:0]   fu_op;
    logic [DATA_W-1:0] fu_a, fu_b;
    logic [TAG_W-1:0]  fu_tag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rs_pool u_rs_pool (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .iss_valid (iss_valid), .iss_op (iss_op),
        .iss_a_rdy (iss_a_rdy), .iss_a_val (iss_a_val), .iss_a_tag (iss_a_tag),
        .iss_b_rdy (iss_b_rdy), .iss_b_val (iss_b_val), .iss_b_tag (iss_b_tag),
        .iss_ready (iss_ready), .iss_tag (iss_tag),
        .bus_valid (bus_valid), .bus_tag (bus_tag), .bus_value (bus_value),
        .fu_ready (fu_ready), .fu_valid (fu_valid), .fu_op (fu_op),
        .fu_a (fu_a), .fu_b (fu_b), .fu_tag (fu_tag)
    );

    // op, a, b : all sources ready at issue
    localparam logic [35:0] VEC [4] = '{
        {4'h1, 16'h0001, 16'h0002},
        {4'hA, 16'hFFFF, 16'h0000},
        {4'h5, 16'h1234, 16'hABCD},
        {4'hF, 16'h8000, 16'h7FFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [3:0] op,
                         input logic ar, input logic [15:0] av, input logic [3:0] at,
                         input logic br, input logic [15:0] bv, input logic [3:0] bt);
        iss_valid = 1'b1; iss_op = op;
        iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
        iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
        tick();
        iss_valid = 1'b0;
        #1;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [15:0] v);
        bus_valid = 1'b1; bus_tag = t; bus_value = v;
        tick();
        bus_valid = 1'b0;
        #1;
    endtask

    task automatic fire_one();
        fu_ready = 1'b1;
        tick();
        fu_ready = 1'b0;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] t;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ready after reset", iss_ready, 1);
        chk("R1 tag after reset", iss_tag, 4'h4);
        chk("R6 no offer after reset", fu_valid, 0);

        // R3 table of fully ready issues
        for (int k = 0; k < 4; k++) begin
            issue(VEC[k][35:32], 1'b1, VEC[k][31:16], 4'h0, 1'b1, VEC[k][15:0], 4'h0);
            chk("R3 valid", fu_valid, 1);
            chk("R3 op", fu_op, VEC[k][35:32]);
            chk("R3 a", fu_a, VEC[k][31:16]);
            chk("R3 b", fu_b, VEC[k][15:0]);
            chk("R3 tag", fu_tag, 4'h4);
            tick();
            chk("R8 held while unit busy", fu_valid, 1);
            fire_one();
            chk("R8 not offered again", fu_valid, 0);
            chk("R9 still occupied", iss_tag, 4'h5);
            bcast(4'h4, 16'h0);
            chk("R9 freed after broadcast", iss_tag, 4'h4);
        end

        // R4 capture by tag
        issue(4'h2, 1'b0, 16'h0, 4'h9, 1'b1, 16'h0077, 4'h0);
        chk("R6 waiting not offered", fu_valid, 0);
        bcast(4'h8, 16'hDEAD);
        chk("R4 foreign tag ignored", fu_valid, 0);
        bcast(4'h9, 16'h1234);
        chk("R4 captured valid", fu_valid, 1);
        chk("R4 captured value", fu_a, 16'h1234);
        chk("R4 other source", fu_b, 16'h0077);
        t = fu_tag; fire_one(); bcast(t, 16'h0);

        // R5 bypass at issue
        iss_valid = 1'b1; iss_op = 4'h3;
        iss_a_rdy = 1'b0; iss_a_tag = 4'hA; iss_b_rdy = 1'b1; iss_b_val = 16'h0011;
        bus_valid = 1'b1; bus_tag = 4'hA; bus_value = 16'h55AA;
        tick();
        iss_valid = 1'b0; bus_valid = 1'b0;
        #1;
        chk("R5 bypass valid", fu_valid, 1);
        chk("R5 bypass value", fu_a, 16'h55AA);
        t = fu_tag; fire_one(); bcast(t, 16'h0);

        // R7 oldest first, R2 full stall
        issue(4'h4, 1'b0, 16'h0, 4'hB, 1'b1, 16'h0001, 4'h0);
        issue(4'h5, 1'b1, 16'h0002, 4'h0, 1'b1, 16'h0003, 4'h0);
        issue(4'h6, 1'b1, 16'h0004, 4'h0, 1'b1, 16'h0005, 4'h0);
        chk("R1 full not ready", iss_ready, 0);
        chk("R7 oldest ready offered", fu_tag, 4'h5);
        issue(4'h7, 1'b1, 16'h0BAD, 4'h0, 1'b1, 16'h0BAD, 4'h0);
        chk("R2 still full", iss_ready, 0);
        bcast(4'hB, 16'h00B0);
        chk("R7 older now ready wins", fu_tag, 4'h4);
        chk("R7 older value", fu_a, 16'h00B0);
        fire_one();
        chk("R7 next oldest", fu_tag, 4'h5);
        fire_one();
        chk("R7 last", fu_tag, 4'h6);
        fire_one();
        chk("R2 stalled issue dropped", fu_valid, 0);
        bcast(4'h4, 16'h0); bcast(4'h5, 16'h0); bcast(4'h6, 16'h0);
        chk("R9 all freed", iss_tag, 4'h4);

        // R11 order kept after slot reuse
        issue(4'h1, 1'b1, 16'h0001, 4'h0, 1'b1, 16'h0001, 4'h0);
        issue(4'h2, 1'b0, 16'h0, 4'hC, 1'b1, 16'h0002, 4'h0);
        issue(4'h3, 1'b0, 16'h0, 4'hD, 1'b1, 16'h0003, 4'h0);
        fire_one();
        bcast(4'h4, 16'h0);
        chk("R11 slot reused", iss_tag, 4'h4);
        issue(4'h8, 1'b0, 16'h0, 4'hE, 1'b1, 16'h0008, 4'h0);
        bcast(4'hE, 16'h00E0);
        chk("R11 young alone", fu_tag, 4'h4);
        bcast(4'hD, 16'h00D0);
        chk("R11 older high index wins", fu_tag, 4'h6);
        bcast(4'hC, 16'h00C0);
        chk("R11 oldest wins", fu_tag, 4'h5);

        // R10 flush
        flush = 1'b1;
        tick();
        flush = 1'b0;
        #1;
        chk("R10 ready after flush", iss_ready, 1);
        chk("R10 tag after flush", iss_tag, 4'h4);
        chk("R10 no offer after flush", fu_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule